// File: doc/BRIEF.md
# ADC Conversion Sequencer and Result Formatter

This block controls a successive-approximation converter and shapes the data it returns. It holds a 16-bit control word with three live fields: a resolution code, a read-back format flag and a low-power flag. When a start pulse is accepted, it counts conversion clocks. The count length is set by the resolution in force at that moment. At the end of the count it captures the converter's output, raises a one-cycle completion pulse and keeps the result as plain unsigned binary.

Software reaches the block through a small register bus with two locations. Location 0 is the control word. Location 1 is the last result. A read of location 1 gives one of two views of the stored value. The first is the value right-aligned and unsigned. The second is a left-aligned two's-complement value, formed by inverting the result's top bit. The resolution and low-power fields are locked while the conversion-enable input is high. The format flag can be changed at any time.

Top module: `adc_ctrl_fmt`

## Requirements
- R1: After reset, location 0 reads 0x0020 (resolution code 2'b10, format 0, low-power 0), and location 1 reads 0x0000. Writes go only to location 0. A write to location 1 is ignored.
- R2: In the control word, the resolution code is at bits 5:4, the format flag at bit 3 and the low-power flag at bit 0. Bits 15:6 and 2:1 always read 0, whatever was written to them.
- R3: While conv_en is high, a write to location 0 leaves the resolution code and the low-power flag unchanged. The format flag still takes the written value.
- R4: A write of resolution code 2'b11 leaves the resolution code unchanged. The other fields of that write still apply.
- R5: A start is accepted on a clock edge where conv_start and conv_en are high and no conversion is running. conv_done is then high for exactly one cycle, after exactly N further clock edges, where N is 10, 12 or 14 for codes 2'b00, 2'b01 and 2'b10 at the accepting edge.
- R6: A start pulse is ignored while a conversion is running or while conv_en is low. It does not restart the count, and it does not add a completion pulse.
- R7: At completion, the block stores the low W bits of ana_result, where W is 8, 10 or 12 for the conversion's resolution. With format 0, location 1 returns that value right-aligned, with zero upper bits.
- R8: With format 1, location 1 returns the stored value with its top bit inverted, shifted left so that this bit sits at bit 15, and with zeros below. For 12-bit results, 0x000 gives 0x8000, 0xFFF gives 0x7FF0 and 0x800 gives 0x0000. For 8-bit results, 0xFF gives 0x7F00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 1 | Register location: 0 control, 1 result |
| reg_wdata | input | 16 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 16 | Register read data, combinational on reg_addr |
| conv_en | input | 1 | Conversion enable; locks resolution and low-power fields |
| conv_start | input | 1 | Conversion start request |
| ana_result | input | 12 | Right-aligned converter output, sampled at completion |
| conv_done | output | 1 | One-cycle completion pulse |

## Verification
A wrong conversion count shows up right away as a completion pulse that comes early or late. The bench measures this edge-exactly at every resolution. If the block latched the wrong resolution or field, it would show on the next read of location 0, or as a result with the wrong width and alignment at the next read of location 1. Reading each result in both formats at zero, mid-scale and full scale exposes a fault in the shift or in the sign inversion within one bus read of completion. Extra or missing pulses caused by a restart during a busy period are caught by the scoreboard as an unmatched completion.

// File: rtl/adc_ctrl_fmt.sv
module adc_ctrl_fmt #(
  parameter int DW = 16,
  parameter int RW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          reg_we,
  output logic [DW-1:0] reg_rdata,
  input  logic          conv_en,
  input  logic          conv_start,
  input  logic [RW-1:0] ana_result,
  output logic          conv_done
);
  localparam logic [1:0] RES_RST = 2'b10;
  localparam int CW = 4;

  logic [1:0]    res_q, cres_q, rres_q;
  logic          fmt_q, lp_q, busy, done_q;
  logic [CW-1:0] cnt;
  logic [RW-1:0] raw_q, keep;
  logic [DW-1:0] ctrl_word, sview;

  function automatic logic [CW-1:0] conv_len(input logic [1:0] r);
    return CW'(10) + {1'b0, r, 1'b0};
  endfunction

  wire wr_ctrl = reg_we && !reg_addr;
  wire accept  = conv_start && conv_en && !busy;
  wire unused_wbits = &{1'b0, reg_wdata[DW-1:6], reg_wdata[2:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= RES_RST;
      fmt_q <= 1'b0;
      lp_q  <= 1'b0;
    end else if (wr_ctrl) begin
      fmt_q <= reg_wdata[3];
      if (!conv_en) begin
        lp_q <= reg_wdata[0];
        if (reg_wdata[5:4] != 2'b11) res_q <= reg_wdata[5:4];
      end
    end
  end

  always_comb begin
    case (cres_q)
      2'b00:   keep = {{(RW-8){1'b0}}, ana_result[7:0]};
      2'b01:   keep = {{(RW-10){1'b0}}, ana_result[9:0]};
      default: keep = ana_result;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      done_q <= 1'b0;
      cres_q <= RES_RST;
      rres_q <= RES_RST;
      raw_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        cnt    <= conv_len(res_q) - CW'(1);
        cres_q <= res_q;
      end else if (busy) begin
        if (cnt == '0) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
          raw_q  <= keep;
          rres_q <= cres_q;
        end else begin
          cnt <= cnt - CW'(1);
        end
      end
    end
  end

  always_comb begin
    case (rres_q)
      2'b00:   sview = {~raw_q[7],  raw_q[6:0],  8'h00};
      2'b01:   sview = {~raw_q[9],  raw_q[8:0],  6'b0};
      default: sview = {~raw_q[11], raw_q[10:0], 4'b0};
    endcase
  end

  assign ctrl_word = {{(DW-6){1'b0}}, res_q, fmt_q, 2'b00, lp_q};
  assign reg_rdata = !reg_addr ? ctrl_word
                   : (fmt_q ? sview : {{(DW-RW){1'b0}}, raw_q});
  assign conv_done = done_q;
endmodule

// File: rtl/adc_ctrl_fmt_chk.sv
module adc_ctrl_fmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_addr,
  input logic        reg_we,
  input logic [15:0] reg_rdata,
  input logic        conv_en,
  input logic        conv_start,
  input logic        conv_done,
  input logic        busy,
  input logic [3:0]  cnt,
  input logic [1:0]  res_q,
  input logic        lp_q
);
  logic [4:0] chk_cnt, chk_len;
  logic       chk_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_cnt <= '0;
      chk_len <= '0;
      chk_act <= 1'b0;
    end else if (conv_start && conv_en && !busy) begin
      chk_cnt <= '0;
      chk_len <= 5'd10 + {2'b0, res_q, 1'b0};
      chk_act <= 1'b1;
    end else if (conv_done) begin
      chk_act <= 1'b0;
    end else if (chk_act) begin
      chk_cnt <= chk_cnt + 5'd1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !conv_done); // R5
  AST_DONE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> (chk_act && chk_cnt == chk_len)); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_addr |-> (reg_rdata[15:6] == '0 && reg_rdata[2:1] == '0)); // R2
  AST_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_en && reg_we && !reg_addr) |=> ($stable(res_q) && $stable(lp_q))); // R3
  AST_RES_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    res_q != 2'b11); // R4
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - 4'd1)); // R6
endmodule

bind adc_ctrl_fmt adc_ctrl_fmt_chk u_chk (.*);

// File: tb/tb_adc_ctrl_fmt.sv
module tb_adc_ctrl_fmt;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_addr = 1'b0, reg_we = 1'b0, conv_en = 1'b0, conv_start = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [11:0] ana_result = '0;
  logic        conv_done;

  int nchk = 0, nfail = 0, ndone = 0, cyc = 0;
  bit trk = 0;
  int exp_q[$];
  int cur_res = 2;

  adc_ctrl_fmt dut (.*);

  always #2 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (trk) cyc++;
    if (rst_n && conv_start && conv_en && !trk) begin trk = 1; cyc = 0; end
    if (conv_done) begin
      ndone++;
      if (exp_q.size() == 0) chk("R6 unexpected done", 1, 0);
      else chk("R5 conversion length", cyc, exp_q.pop_front());
      trk = 0;
    end
  end

  task automatic wr(logic [15:0] d);
    @(negedge clk); reg_addr = 0; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic a, output logic [15:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic convert(logic [11:0] v);
    @(negedge clk); ana_result = v; conv_start = 1; exp_q.push_back(10 + 2 * cur_res);
    @(negedge clk); conv_start = 0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_case(logic [11:0] v, logic [15:0] eu, logic [15:0] es);
    logic [15:0] r;
    convert(v); wait_idle();
    wr(16'(cur_res << 4));
    rd(1, r); chk("R7 unsigned view", r, eu);
    wr(16'(cur_res << 4) | 16'h0008);
    rd(1, r); chk("R8 signed view", r, es);
  endtask

  initial begin
    #(200000 * 4);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] r;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, r); chk("R1 control reset", r, 16'h0020);
    rd(1, r); chk("R1 result reset", r, 16'h0000);

    @(negedge clk); reg_addr = 1; reg_wdata = 16'h0019; reg_we = 1;
    @(negedge clk); reg_we = 0;
    rd(0, r); chk("R1 write to location 1 ignored", r, 16'h0020);

    for (int res = 0; res < 3; res++) begin
      conv_en = 0; cur_res = res;
      wr(16'(res << 4));
      rd(0, r); chk("R2 resolution field", r, 16'(res << 4));
      conv_en = 1;
      case (res)
        0: begin
          run_case(12'h000, 16'h0000, 16'h8000);
          run_case(12'h0FF, 16'h00FF, 16'h7F00);
          run_case(12'h080, 16'h0080, 16'h0000);
          run_case(12'hABC, 16'h00BC, 16'h3C00);
        end
        1: begin
          run_case(12'h000, 16'h0000, 16'h8000);
          run_case(12'h3FF, 16'h03FF, 16'h7FC0);
          run_case(12'h200, 16'h0200, 16'h0000);
          run_case(12'hC01, 16'h0001, 16'h8040);
        end
        default: begin
          run_case(12'h000, 16'h0000, 16'h8000);
          run_case(12'hFFF, 16'h0FFF, 16'h7FF0);
          run_case(12'h800, 16'h0800, 16'h0000);
        end
      endcase
    end

    conv_en = 1;
    wr(16'h0009);
    rd(0, r); chk("R3 locked fields kept, format taken", r, 16'h0028);

    conv_en = 0;
    wr(16'h0010);
    wr(16'h0030);
    rd(0, r); chk("R4 reserved code keeps resolution", r, 16'h0010);
    wr(16'hFFFF);
    rd(0, r); chk("R2 reserved bits read zero", r, 16'h0019);
    wr(16'h0010); cur_res = 1;

    conv_en = 1;
    base = ndone;
    convert(12'h123);
    repeat (3) @(negedge clk);
    conv_start = 1; ana_result = 12'h123;
    @(negedge clk); conv_start = 0;
    wait_idle();
    repeat (20) @(negedge clk);
    chk("R6 start while busy ignored", ndone - base, 1);

    conv_en = 0; base = ndone;
    @(negedge clk); conv_start = 1;
    @(negedge clk); conv_start = 0;
    repeat (20) @(negedge clk);
    chk("R6 start while disabled ignored", ndone - base, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule